// File: doc/BRIEF.md
# I2C SCL Clock Generator

This block produces the serial clock for an I2C master from the peripheral clock. A 12-bit divider, a fast/standard select and a duty select set how many input-clock cycles SCL is held low and how many it is left high. The block drives SCL only by pulling it low. It watches the sensed SCL line so that a slave can stretch the clock, and so that another master pulling SCL low cuts the high phase short. Single-cycle tick outputs mark the start of each low phase and each high phase for the byte engine that shifts data.

A 6-bit rise-time allowance lets the cycles spent waiting for SCL to rise count toward the high phase. The nominal period is then kept on a slow bus, and a slow rise is never counted twice. When the enable is low, the generator releases SCL and stays idle. When it is enabled again, it starts with a fresh low phase.

Top module: `scl_clk_gen`

## Requirements
- R1: With the fast select low, the low phase lasts B input-clock cycles and the high phase lasts B cycles, where B is the divider value.
- R2: With the fast select high and the duty select low, the low phase lasts 2×B cycles and the high phase lasts B cycles.
- R3: With the fast select high and the duty select high, the low phase lasts 16×B cycles and the high phase lasts 9×B cycles.
- R4: A divider value of 0 gives the same timing as a divider value of 1.
- R5: After SCL is released, the high-phase count does not start until sampled SCL reads 1. A line held low therefore extends the released time by every cycle it stays low.
- R6: Each cycle that sampled SCL reads 0 while the generator waits for it to rise earns one cycle of credit, up to the rise-time allowance. The high phase, counted from the first cycle after SCL is seen high, lasts its nominal length minus that credit, and always lasts at least 1 cycle.
- R7: If sampled SCL reads 0 during the high phase, the generator drives SCL low from the next cycle and starts a full low phase.
- R8: `fallTick` is a one-cycle pulse in the first cycle that `sclDriveLow` is 1 in each low phase. `riseTick` is a one-cycle pulse in the first cycle of each high phase, which is the cycle after the one in which SCL is first sampled high.
- R9: One cycle after the enable goes low, `sclDriveLow` is 0 and both ticks stay 0 for as long as the enable is low. The first cycle after the enable returns starts a full low phase, with a `fallTick`.
- R10: During reset and directly after it, with the enable low, `sclDriveLow`, `fallTick` and `riseTick` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the generator when 1 |
| ccrDiv | input | 12 | Divider value B |
| dutySel | input | 1 | Fast-mode duty select (0: 2:1, 1: 16:9) |
| fastSel | input | 1 | 1 selects fast mode, 0 selects standard mode |
| riseAllow | input | 6 | Maximum rise-wait credit, in cycles |
| sclIn | input | 1 | Sensed SCL level, already synchronous to clk |
| sclDriveLow | output | 1 | 1 pulls SCL low; 0 releases it |
| fallTick | output | 1 | Pulse in the first cycle of a low phase |
| riseTick | output | 1 | Pulse in the first cycle of a high phase |

## Verification
Every output is registered, so a change on `enable` or `sclIn` sampled at one edge shows up on the outputs for the whole following cycle. The bench drives SCL half a cycle after each edge, from its own count of released cycles, and reads the outputs at the falling edge of the clock. For each phase it predicts three things from the mode, the divider, the rise delay it applied and the allowance: the number of driven-low cycles, the number of released cycles, and the released cycle in which `riseTick` must appear. When it pulls the line low during the high phase, it expects the released time to end at the cycle of the pull. After the enable drops, it expects the outputs to be quiet from the next sampled cycle on.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_RISE = 2'd2,
    PH_HIGH = 2'd3
  } phase_e;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic loadLow;   // count <- low length - 1
    logic loadHigh;  // count <- high length - 1 - credit
    logic decr;      // count <- count - 1
    logic clrWait;   // rise-wait counter <- 0
    logic incWait;   // rise-wait counter += 1, saturating
  } strobe_t;

endpackage

// File: rtl/sclgen_datapath.sv
module sclgen_datapath
  import sclgen_pkg::*;
#(
  parameter int DIV_W  = 12,
  parameter int RISE_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  ccrDiv,
  input  logic              dutySel,
  input  logic              fastSel,
  input  logic [RISE_W-1:0] riseAllow,
  input  strobe_t           strb,
  output logic              cntZero
);

  // 16*B is the largest length, so four extra bits hold it
  localparam int CNT_W = DIV_W + 4;

  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] lowLen;
  logic [CNT_W-1:0] highLen;
  logic [CNT_W-1:0] credit;
  logic [CNT_W-1:0] waitExt;
  logic [CNT_W-1:0] allowExt;
  logic [CNT_W-1:0] capExt;
  logic [CNT_W-1:0] count;
  logic [RISE_W-1:0] waitCnt;

  // A zero divider is treated as one so the clock cannot stall
  always_comb begin
    base = {{(CNT_W-DIV_W){1'b0}}, ccrDiv};
    if (ccrDiv == '0) base = {{(CNT_W-1){1'b0}}, 1'b1};
  end

  always_comb begin
    unique case ({fastSel, dutySel})
      2'b10:   begin lowLen = base << 1; highLen = base; end
      2'b11:   begin lowLen = base << 4; highLen = (base << 3) + base; end
      default: begin lowLen = base;      highLen = base; end
    endcase
  end

  // credit = min(waited, allowance, highLen-1)
  always_comb begin
    waitExt  = {{(CNT_W-RISE_W){1'b0}}, waitCnt};
    allowExt = {{(CNT_W-RISE_W){1'b0}}, riseAllow};
    capExt   = highLen - 1'b1;
    credit   = (waitExt < allowExt) ? waitExt : allowExt;
    if (credit > capExt) credit = capExt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strb.loadLow) begin
      count <= lowLen - 1'b1;
    end else if (strb.loadHigh) begin
      count <= highLen - 1'b1 - credit;
    end else if (strb.decr) begin
      count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else if (strb.clrWait) begin
      waitCnt <= '0;
    end else if (strb.incWait && (waitCnt != {RISE_W{1'b1}})) begin
      waitCnt <= waitCnt + 1'b1;
    end
  end

  assign cntZero = (count == '0);

  // R6: the loaded high count always leaves at least one high cycle
  p_high_load_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadHigh |=> (count < $past(highLen)));

  // R1: control never counts down past zero
  p_no_underflow_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.decr |-> !cntZero);

endmodule

// File: rtl/sclgen_ctrl.sv
module sclgen_ctrl
  import sclgen_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  logic    sclIn,
  input  logic    cntZero,
  output strobe_t strb,
  output logic    sclDriveLow,
  output logic    fallTick,
  output logic    riseTick
);

  phase_e phase, phaseNext;
  logic   fallNext, riseNext;

  always_comb begin
    phaseNext = phase;
    strb      = '0;
    fallNext  = 1'b0;
    riseNext  = 1'b0;
    if (!enable) begin
      phaseNext = PH_IDLE;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          phaseNext    = PH_LOW;
          strb.loadLow = 1'b1;
          fallNext     = 1'b1;
        end
        PH_LOW: begin
          if (cntZero) begin
            phaseNext    = PH_RISE;
            strb.clrWait = 1'b1;
          end else begin
            strb.decr = 1'b1;
          end
        end
        PH_RISE: begin
          if (sclIn) begin
            phaseNext     = PH_HIGH;
            strb.loadHigh = 1'b1;
            riseNext      = 1'b1;
          end else begin
            strb.incWait = 1'b1;
          end
        end
        PH_HIGH: begin
          if (!sclIn || cntZero) begin
            phaseNext    = PH_LOW;
            strb.loadLow = 1'b1;
            fallNext     = 1'b1;
          end else begin
            strb.decr = 1'b1;
          end
        end
        default: phaseNext = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase       <= PH_IDLE;
      sclDriveLow <= 1'b0;
      fallTick    <= 1'b0;
      riseTick    <= 1'b0;
    end else begin
      phase       <= phaseNext;
      sclDriveLow <= (phaseNext == PH_LOW);
      fallTick    <= fallNext;
      riseTick    <= riseNext;
    end
  end

  p_release_when_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!sclDriveLow && !fallTick && !riseTick));

  p_sync_to_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    (enable && phase == PH_HIGH && !sclIn) |=> (sclDriveLow && fallTick));

  p_stretch_holds_r5: assert property (@(posedge clk) disable iff (!rstN)
    (enable && phase == PH_RISE && !sclIn) |=> (!sclDriveLow && !riseTick));

  p_fall_marks_edge_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclDriveLow) |-> fallTick);

  p_rise_tick_released_r8: assert property (@(posedge clk) disable iff (!rstN)
    riseTick |-> !sclDriveLow);

  p_reset_quiet_r10: assert property (@(posedge clk)
    !rstN |-> (!sclDriveLow && !fallTick && !riseTick));

endmodule

// File: rtl/scl_clk_gen.sv
module scl_clk_gen
  import sclgen_pkg::*;
#(
  parameter int DIV_W  = 12,
  parameter int RISE_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [DIV_W-1:0]  ccrDiv,
  input  logic              dutySel,
  input  logic              fastSel,
  input  logic [RISE_W-1:0] riseAllow,
  input  logic              sclIn,
  output logic              sclDriveLow,
  output logic              fallTick,
  output logic              riseTick
);

  strobe_t strb;
  logic    cntZero;

  sclgen_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .sclIn       (sclIn),
    .cntZero     (cntZero),
    .strb        (strb),
    .sclDriveLow (sclDriveLow),
    .fallTick    (fallTick),
    .riseTick    (riseTick)
  );

  sclgen_datapath #(.DIV_W(DIV_W), .RISE_W(RISE_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ccrDiv    (ccrDiv),
    .dutySel   (dutySel),
    .fastSel   (fastSel),
    .riseAllow (riseAllow),
    .strb      (strb),
    .cntZero   (cntZero)
  );

endmodule

// File: tb/tb_scl_clk_gen.sv
module tb_scl_clk_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [11:0] ccrDiv = '0;
  logic        dutySel = 1'b0;
  logic        fastSel = 1'b0;
  logic [5:0]  riseAllow = '0;
  logic        sclIn = 1'b1;
  logic        sclDriveLow, fallTick, riseTick;

  always #10 clk = ~clk;  // 50 MHz

  scl_clk_gen dut (
    .clk(clk), .rstN(rstN), .enable(enable), .ccrDiv(ccrDiv),
    .dutySel(dutySel), .fastSel(fastSel), .riseAllow(riseAllow),
    .sclIn(sclIn), .sclDriveLow(sclDriveLow), .fallTick(fallTick),
    .riseTick(riseTick)
  );

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  // bench line model
  int dly = 0;       // released cycles SCL stays low before rising
  int pullAt = 0;    // released cycle index with forced low, 0 = none
  int relCnt = 0;
  int lowRun = 0;
  bit prevDrive = 1'b0;
  bit mon = 1'b0;
  bit armed = 1'b0;
  int falls = 0;
  string tagLow = "R1";
  string tagRel = "R1";

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  function automatic int baseVal();
    return (ccrDiv == 0) ? 1 : int'(ccrDiv);
  endfunction

  function automatic int expLow();
    if (!fastSel) return baseVal();
    return dutySel ? 16 * baseVal() : 2 * baseVal();
  endfunction

  function automatic int expHigh();
    if (!fastSel) return baseVal();
    return dutySel ? 9 * baseVal() : baseVal();
  endfunction

  function automatic int expCredit();
    int c;
    c = dly;
    if (c > 63) c = 63;
    if (c > int'(riseAllow)) c = int'(riseAllow);
    if (c > expHigh() - 1) c = expHigh() - 1;
    return c;
  endfunction

  function automatic int expRel();
    if (pullAt != 0) return pullAt;
    return dly + 1 + expHigh() - expCredit();
  endfunction

  always @(negedge clk) begin
    int nRel;
    nRel = sclDriveLow ? 0 : relCnt + 1;
    if (mon) begin
      chk(fallTick === (sclDriveLow && !prevDrive), "R8 fallTick", int'(fallTick),
          int'(sclDriveLow && !prevDrive));
      chk(riseTick === (nRel == dly + 2), "R8 riseTick", int'(riseTick), int'(nRel == dly + 2));
      if (sclDriveLow && !prevDrive) begin
        falls++;
        if (armed) chk(relCnt == expRel(), tagRel, relCnt, expRel());
        armed = 1'b1;
      end
      if (!sclDriveLow && prevDrive) chk(lowRun == expLow(), tagLow, lowRun, expLow());
    end else begin
      armed = 1'b0;
    end
    lowRun    = sclDriveLow ? (prevDrive ? lowRun + 1 : 1) : 0;
    relCnt    = nRel;
    prevDrive = sclDriveLow;
    sclIn    <= (nRel > dly) && !(pullAt != 0 && nRel == pullAt);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=<190000", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic runCfg(input int c, input bit fs, input bit dt, input int ra,
                        input int d, input int p, input int periods,
                        input string tl, input string tr);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    ccrDiv = 12'(c); fastSel = fs; dutySel = dt; riseAllow = 6'(ra);
    dly = d; pullAt = p; tagLow = tl; tagRel = tr;
    @(negedge clk);
    enable = 1'b1;
    @(posedge clk);
    falls = 0;
    mon = 1'b1;
    while (falls < periods + 1) @(negedge clk);
    @(posedge clk);
    mon = 1'b0;
    @(negedge clk);
    enable = 1'b0;
  endtask

  initial begin
    int seedv;
    seedv = 32'h5C1A0E;
    void'($urandom(seedv));

    // R10: reset state
    repeat (3) @(negedge clk);
    chk(!sclDriveLow && !fallTick && !riseTick, "R10 in reset", int'(sclDriveLow), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(!sclDriveLow && !fallTick && !riseTick, "R10 after reset", int'(sclDriveLow), 0);

    // Directed cases
    runCfg(5,    0, 0, 0, 0, 0, 3, "R1 low", "R1 released");
    runCfg(4,    1, 0, 0, 0, 0, 3, "R2 low", "R2 released");
    runCfg(3,    1, 1, 0, 0, 0, 2, "R3 low", "R3 released");
    runCfg(0,    0, 0, 0, 0, 0, 3, "R4 low", "R4 released");
    runCfg(0,    1, 1, 0, 0, 0, 2, "R4 fast low", "R4 fast released");
    runCfg(4095, 0, 0, 0, 0, 0, 1, "R1 max low", "R1 max released");
    runCfg(6,    0, 0, 5, 100, 0, 2, "R5 low", "R5 stretch released");
    runCfg(10,   1, 0, 4, 7, 0, 3, "R6 low", "R6 credit released");
    runCfg(2,    0, 0, 20, 5, 0, 3, "R6 low", "R6 floor released");
    runCfg(12,   0, 0, 0, 1, 5, 3, "R7 low", "R7 sync released");
    runCfg(3,    1, 1, 2, 3, 9, 3, "R7 low", "R7 sync fast released");

    // R9: disable in mid low phase, then restart
    @(negedge clk);
    ccrDiv = 12'd50; fastSel = 1'b0; dutySel = 1'b0; dly = 0; pullAt = 0;
    enable = 1'b1;
    repeat (10) @(negedge clk);
    chk(sclDriveLow == 1'b1, "R9 driving before disable", int'(sclDriveLow), 1);
    enable = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(!sclDriveLow && !fallTick && !riseTick, "R9 released while off",
          int'(sclDriveLow), 0);
    end
    enable = 1'b1;
    @(negedge clk);
    chk(sclDriveLow && fallTick, "R9 restart low phase", int'(sclDriveLow && fallTick), 1);
    runCfg(50, 0, 0, 0, 0, 0, 1, "R9 restart low", "R1 released");

    // Constrained random configurations
    for (int k = 0; k < 14; k++) begin
      int c, ra, d, p, h, cr;
      bit fs, dt;
      c  = $urandom_range(0, 30);
      fs = 1'($urandom_range(0, 1));
      dt = 1'($urandom_range(0, 1));
      ra = $urandom_range(0, 12);
      d  = $urandom_range(0, 15);
      h  = (c == 0) ? 1 : c;
      if (fs && dt) h = 9 * h;
      cr = (d < ra) ? d : ra;
      if (cr > h - 1) cr = h - 1;
      p  = 0;
      if ($urandom_range(0, 2) == 0 && (h - cr) >= 2)
        p = d + 2 + $urandom_range(0, h - cr - 2);
      runCfg(c, fs, dt, ra, d, p, 3,
             fs ? (dt ? "R3 rand low" : "R2 rand low") : "R1 rand low",
             (p != 0) ? "R7 rand released" : "R6 rand released");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule